// File: doc/BRIEF.md
# E1 Frame and Channel Timing Generator

This block produces the bit, time-slot and frame timing of a 2.048 Mbit/s E1 serial stream. Every rising edge of `clk` is one bit period. A frame is 32 slots of 8 bits, 256 bits in all, and slot 0 comes first. Within a slot, bit index 0 carries the most significant bit and is first in time. Bit index 7 carries the least significant bit and is last. Sixteen frames form a multiframe. The current position is brought out as bit, slot and frame indices, so the neighbouring framing and signalling logic can decode it.

Three strobes are derived from that position. A channel clock is high during the last bit of every slot. A channel gate output follows a 32-entry mask, one bit per slot, and holds its value for the whole slot; this is used to block the clock of unused channels in fractional-E1 setups. A sync strobe one bit period wide marks either every frame start or only the multiframe start. The block can also be switched so that the sync line is an input: an external pulse then realigns the counters and the strobe output stays quiet. The mask is written through a one-cycle synchronous write port.

Top module: `e1_slot_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bit, slot and frame indices become 0 and every mask entry becomes 0. After reset is released the indices read 0/0/0 and `chan_blk` is 0.
- R2: With no realignment, the bit index counts 0 to 7 and wraps. The slot index advances by one when the bit index wraps and counts 0 to 31. The frame index advances by one when both wrap and counts 0 to 15.
- R3: `chan_clk` is 1 exactly in the cycles where the bit index is 7, the least significant bit of the slot.
- R4: `chan_blk` equals mask entry N in all 8 bit periods of slot N.
- R5: A write with `mask_we`=1 stores `mask_wdata` into entry `mask_addr` at that clock edge. The change is visible on `chan_blk` from the next cycle, including when the entry written is the slot currently being presented.
- R6: With `cfg_sync_in`=0 and `cfg_mf_sel`=0, `sync_out` is 1 exactly in the cycle where bit index 0 and slot index 0 coincide, once per frame.
- R7: With `cfg_sync_in`=0 and `cfg_mf_sel`=1, `sync_out` is 1 only when the bit, slot and frame indices are all 0, once per 16 frames.
- R8: With `cfg_sync_in`=1, `sync_out` stays 0.
- R9: With `cfg_sync_in`=1, `sync_in`=1 at a clock edge sets the bit and slot indices to 0 in the next cycle. The frame index is set to 0 if `cfg_mf_sel`=1 and is left unchanged if `cfg_mf_sel`=0. This holds even when the pulse falls on the last bit of a frame.
- R10: With `cfg_sync_in`=0, `sync_in` has no effect on the indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one edge per E1 bit |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sync_in | input | 1 | 1: sync line acts as input; 0: sync strobe is generated |
| cfg_mf_sel | input | 1 | 1: align to and mark multiframes; 0: frames only |
| sync_in | input | 1 | External alignment pulse, used when `cfg_sync_in`=1 |
| mask_we | input | 1 | Mask write strobe |
| mask_addr | input | 5 | Mask entry (slot number) to write |
| mask_wdata | input | 1 | Value written to the mask entry |
| bit_idx | output | 3 | Bit position in the slot, 0 = MSB |
| slot_idx | output | 5 | Time slot number |
| frame_idx | output | 4 | Frame number in the multiframe |
| chan_clk | output | 1 | High during the last bit of every slot |
| chan_blk | output | 1 | Mask entry of the current slot |
| sync_out | output | 1 | Frame or multiframe start strobe |

## Verification
Two pairs of events can land on the same edge. The first is an external alignment pulse on the last bit of slot 31, where the counters would wrap anyway. The second is a mask write that targets the slot being presented, issued in the middle of that slot. Both are forced by directed steps inside constrained-random runs, in both alignment modes. A reference model in the bench applies the realignment ahead of the natural advance, and the mask write one cycle after its edge. It then compares indices, channel gate and strobe in every cycle.

// File: rtl/e1t_pkg.sv
// Package e1t_pkg: shared E1 geometry defaults for the slot timer.
// Assumes a frame of fixed-size slots and a power-of-two friendly layout.
package e1t_pkg;
    localparam int E1_BITS   = 8;   // bits per time slot
    localparam int E1_SLOTS  = 32;  // time slots per frame
    localparam int E1_FRAMES = 16;  // frames per multiframe
endpackage

// File: rtl/e1t_counter.sv
// e1t_counter: nested bit / slot / frame position counters.
// Advances one bit per clock; a reload returns to the first bit of slot 0,
// and also to frame 0 when reload_frame is set. Assumes BITS, SLOTS, FRAMES >= 2.
module e1t_counter #(
    parameter int BITS   = 8,
    parameter int SLOTS  = 32,
    parameter int FRAMES = 16,
    localparam int BW = $clog2(BITS),
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          reload_frame,
    output logic [BW-1:0] bit_q,
    output logic [SW-1:0] slot_q,
    output logic [FW-1:0] frm_q
);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
    localparam logic [FW-1:0] FRM_LAST  = FW'(FRAMES - 1);

    // Position update: reset, external realignment, or normal advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
            frm_q  <= '0;
        end else if (reload) begin
            bit_q  <= '0;
            slot_q <= '0;
            if (reload_frame) begin
                frm_q <= '0;
            end
        end else if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            if (slot_q == SLOT_LAST) begin
                slot_q <= '0;
                frm_q  <= (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/e1t_mask.sv
// e1t_mask: per-slot gate mask, one flop per slot, single-entry writes.
// A write lands at the clock edge where mask_we is high; reset clears all.
module e1t_mask #(
    parameter int SLOTS = 32,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SW-1:0]    addr,
    input  logic             wdata,
    output logic [SLOTS-1:0] mask_q
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_cell
        // Store one slot's gate bit when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (we && addr == SW'(i)) begin
                mask_q[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/e1t_sync_gen.sv
// e1t_sync_gen: decodes the frame/multiframe strobe and the realignment
// request from the current position and the two mode bits. Pure logic.
module e1t_sync_gen #(
    parameter int BW = 3,
    parameter int SW = 5,
    parameter int FW = 4
) (
    input  logic          cfg_sync_in,
    input  logic          cfg_mf_sel,
    input  logic          sync_in,
    input  logic [BW-1:0] bit_q,
    input  logic [SW-1:0] slot_q,
    input  logic [FW-1:0] frm_q,
    output logic          sync_out,
    output logic          reload,
    output logic          reload_frame
);
    logic frame_mark;
    logic mf_mark;

    // Strobe decode: frame start, optionally qualified by frame 0.
    always_comb begin
        frame_mark   = (bit_q == '0) && (slot_q == '0);
        mf_mark      = frame_mark && (frm_q == '0);
        sync_out     = !cfg_sync_in && (cfg_mf_sel ? mf_mark : frame_mark);
        reload       = cfg_sync_in && sync_in;
        reload_frame = cfg_mf_sel;
    end
endmodule

// File: rtl/e1_slot_timer.sv
// e1_slot_timer: E1 bit/slot/frame timing with channel clock, channel gate
// and frame or multiframe strobe. One clock edge equals one line bit.
// Assumes mask writes and mode bits are synchronous to clk.
module e1_slot_timer
    import e1t_pkg::*;
#(
    parameter int BITS   = E1_BITS,
    parameter int SLOTS  = E1_SLOTS,
    parameter int FRAMES = E1_FRAMES,
    localparam int BW = $clog2(BITS),
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sync_in,
    input  logic          cfg_mf_sel,
    input  logic          sync_in,
    input  logic          mask_we,
    input  logic [SW-1:0] mask_addr,
    input  logic          mask_wdata,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic [FW-1:0] frame_idx,
    output logic          chan_clk,
    output logic          chan_blk,
    output logic          sync_out
);
    localparam logic [BW-1:0] LSB_POS = BW'(BITS - 1);

    logic             reload;
    logic             reload_frame;
    logic [SLOTS-1:0] mask_vec;

    e1t_counter #(.BITS(BITS), .SLOTS(SLOTS), .FRAMES(FRAMES)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload       (reload),
        .reload_frame (reload_frame),
        .bit_q        (bit_idx),
        .slot_q       (slot_idx),
        .frm_q        (frame_idx)
    );

    e1t_mask #(.SLOTS(SLOTS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .addr   (mask_addr),
        .wdata  (mask_wdata),
        .mask_q (mask_vec)
    );

    e1t_sync_gen #(.BW(BW), .SW(SW), .FW(FW)) u_sync (
        .cfg_sync_in  (cfg_sync_in),
        .cfg_mf_sel   (cfg_mf_sel),
        .sync_in      (sync_in),
        .bit_q        (bit_idx),
        .slot_q       (slot_idx),
        .frm_q        (frame_idx),
        .sync_out     (sync_out),
        .reload       (reload),
        .reload_frame (reload_frame)
    );

    // Channel strobes: LSB marker and the current slot's gate bit.
    always_comb begin
        chan_clk = (bit_idx == LSB_POS);
        chan_blk = mask_vec[slot_idx];
    end
endmodule

// File: rtl/e1t_chk.sv
// e1t_chk: temporal properties of e1_slot_timer, attached by bind below.
module e1t_chk #(
    parameter int BW = 3,
    parameter int SW = 5,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_sync_in,
    input logic          cfg_mf_sel,
    input logic          sync_in,
    input logic          mask_we,
    input logic [BW-1:0] bit_idx,
    input logic [SW-1:0] slot_idx,
    input logic [FW-1:0] frame_idx,
    input logic          chan_clk,
    input logic          chan_blk,
    input logic          sync_out
);
    localparam logic [BW-1:0] BIT_LAST = {BW{1'b1}};

    // R2
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_sync_in && sync_in) |=>
            bit_idx == (($past(bit_idx) == BIT_LAST) ? '0 : $past(bit_idx) + 1'b1));

    // R3
    lsb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_clk && !(cfg_sync_in && sync_in)) |=>
            (bit_idx == '0) && (slot_idx != $past(slot_idx)));

    // R4
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we && !chan_clk && !(cfg_sync_in && sync_in)) |=> $stable(chan_blk));

    // R6
    strobe_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> (bit_idx == 1) && (slot_idx == '0));

    // R7
    mf_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && cfg_mf_sel) |-> frame_idx == '0);

    // R8
    quiet_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sync_in |-> !sync_out);

    // R9
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sync_in && sync_in) |=> (bit_idx == '0) && (slot_idx == '0));
endmodule

bind e1_slot_timer e1t_chk #(.BW(BW), .SW(SW), .FW(FW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sync_in (cfg_sync_in),
    .cfg_mf_sel  (cfg_mf_sel),
    .sync_in     (sync_in),
    .mask_we     (mask_we),
    .bit_idx     (bit_idx),
    .slot_idx    (slot_idx),
    .frame_idx   (frame_idx),
    .chan_clk    (chan_clk),
    .chan_blk    (chan_blk),
    .sync_out    (sync_out)
);

// File: tb/sim_e1_slot_timer.sv
// sim_e1_slot_timer: seeded random plus directed stimulus against a bench model.
module sim_e1_slot_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync_in = 1'b0;
    logic       cfg_mf_sel = 1'b0;
    logic       sync_in = 1'b0;
    logic       mask_we = 1'b0;
    logic [4:0] mask_addr = '0;
    logic       mask_wdata = 1'b0;
    logic [2:0] bit_idx;
    logic [4:0] slot_idx;
    logic [3:0] frame_idx;
    logic       chan_clk;
    logic       chan_blk;
    logic       sync_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    int    m_bit = 0;
    int    m_slot = 0;
    int    m_frm = 0;
    logic [31:0] m_mask = '0;
    string pos_tag = "R1";
    string blk_tag = "R1";

    always #2 clk = ~clk;

    e1_slot_timer u0 (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (bit %0d slot %0d frame %0d)",
                     tag, act, exp, m_bit, m_slot, m_frm);
        end
    endtask

    function automatic int exp_sync();
        if (cfg_sync_in) return 0;
        if (m_bit != 0 || m_slot != 0) return 0;
        return (!cfg_mf_sel || m_frm == 0) ? 1 : 0;
    endfunction

    function automatic string sync_tag();
        if (cfg_sync_in) return "R8";
        return cfg_mf_sel ? "R7" : "R6";
    endfunction

    // Called at a falling edge with inputs set: check, clock, update model.
    task automatic step();
        chk(pos_tag, int'(bit_idx), m_bit);
        chk(pos_tag, int'(slot_idx), m_slot);
        chk(pos_tag, int'(frame_idx), m_frm);
        chk("R3", int'(chan_clk), (m_bit == 7) ? 1 : 0);
        chk(blk_tag, int'(chan_blk), int'(m_mask[m_slot]));
        chk(sync_tag(), int'(sync_out), exp_sync());
        @(posedge clk);
        if (cfg_sync_in && sync_in) begin
            m_bit = 0; m_slot = 0;
            if (cfg_mf_sel) m_frm = 0;
            pos_tag = "R9";
        end else begin
            pos_tag = (sync_in && !cfg_sync_in) ? "R10" : "R2";
            if (m_bit == 7) begin
                m_bit = 0;
                if (m_slot == 31) begin
                    m_slot = 0;
                    m_frm = (m_frm + 1) % 16;
                end else m_slot++;
            end else m_bit++;
        end
        blk_tag = (mask_we && int'(mask_addr) == m_slot) ? "R5" : "R4";
        if (mask_we) m_mask[mask_addr] = mask_wdata;
        @(negedge clk);
    endtask

    task automatic rand_run(int n, int sync_odds);
        for (int i = 0; i < n; i++) begin
            mask_we    = ($urandom % 6) == 0;
            mask_addr  = 5'($urandom);
            mask_wdata = 1'($urandom);
            sync_in    = ($urandom % sync_odds) == 0;
            step();
        end
        mask_we = 1'b0; sync_in = 1'b0;
    endtask

    // Pulse sync on the last bit of a frame (coincides with natural wrap).
    task automatic sync_on_wrap();
        while (!(m_bit == 7 && m_slot == 31)) step();
        sync_in = 1'b1; step(); sync_in = 1'b0;
        step();
    endtask

    // Write the mask entry of the slot currently presented, mid-slot.
    task automatic write_live_slot();
        while (m_bit != 3) step();
        mask_we = 1'b1; mask_addr = 5'(m_slot); mask_wdata = ~m_mask[m_slot];
        step();
        mask_we = 1'b0;
        step(); step();
    endtask

    initial begin
        void'($urandom(32'h5eed_e1e1));
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1", int'(bit_idx), 0);
        chk("R1", int'(chan_blk), 0);
        rst_n = 1'b1;
        step();
        // R6 / R10: frame strobe, random sync ignored in output mode
        rand_run(700, 20);
        write_live_slot();
        // R7: multiframe strobe over more than one multiframe
        cfg_mf_sel = 1'b1;
        rand_run(4300, 50);
        // R8 / R9: input mode, multiframe alignment
        cfg_sync_in = 1'b1;
        rand_run(1500, 400);
        sync_on_wrap();
        write_live_slot();
        rand_run(600, 300);
        // R9: input mode, frame number preserved
        cfg_mf_sel = 1'b0;
        rand_run(1500, 400);
        sync_on_wrap();
        write_live_slot();
        // back to output mode
        cfg_sync_in = 1'b0;
        rand_run(600, 30);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule